// File: doc/BRIEF.md
# Bus Fault Status Capture Registers

This block keeps three 16-bit status words that describe the most recent faulting memory access. When the fault detection logic raises a fault strobe, it also supplies the fault class, the transfer direction, the access size, the 24-bit address and the current parity-interrupt-enable setting. The block turns these into a cause code held in the general status word. It also fills two bus status words: one with a size/lane tag and the top address byte, and one with the low sixteen address bits. The processor exception handler reads these words afterwards.

The processor reaches the words through a small register port that has a select, a byte-lane bit and a write strobe. Select 0 picks the general status word, select 1 the first bus status word and select 2 the second. Select 3 is the clear-status register: it cannot be read, and writing it returns all three words to 0xFFFF. Reads are combinational. They are presented at the same time as a byte, a word and a longword, so the bus interface can pick the width of the cycle in progress.

Top module: `fault_status_regs`

## Requirements
- R1: After reset, all three status words read 0xFFFF.
- R2: The general status code depends on fault class (flt_class: 0 page not present, 1 user access outside RAM, 2 kernel-area access, 3 page not write enabled) and direction (flt_write=1 for a write). A page fault loads 0x8BFF on a write and 0xCBFF on a read. A user-outside-RAM fault loads 0x9AFF on a write and 0xDAFF on a read. The new value is readable after the clock edge that samples flt_valid.
- R3: When par_int_en is high on a class 0 or class 1 fault, bit 10 (0x0400) is also set in the loaded general status value.
- R4: A class 2 or class 3 fault leaves the general status word unchanged and still updates both bus status words.
- R5: On any fault, bus status word 0 is loaded with a tag in bits 15:8 and flt_addr[23:16] in bits 7:0. The tag is 0x7F when flt_size is word (1) or longword (2). For a byte access (flt_size 0), the tag is 0x7E when flt_addr[0] is 0 and 0x7D when it is 1.
- R6: On any fault, bus status word 1 is loaded with flt_addr[15:0].
- R7: A processor write with cpu_sel=3 sets all three words to 0xFFFF at the next clock edge.
- R8: If a fault and a clear-status write arrive in the same cycle, the fault values are kept.
- R9: Processor writes with cpu_sel 0, 1 or 2 are ignored, and the words keep their values.
- R10: rd_word returns the selected word, and reads 0xFFFF for cpu_sel=3. rd_long returns that word in both halves. rd_byte returns bits 15:8 when cpu_lane=0 and bits 7:0 when cpu_lane=1.
- R11: With no fault and no clear-status write, all three words hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Fault strobe, one cycle per fault |
| flt_class | input | 2 | Fault class (0 page, 1 user outside RAM, 2 kernel, 3 no write enable) |
| flt_write | input | 1 | 1 for a faulting write, 0 for a read |
| flt_size | input | 2 | Access size (0 byte, 1 word, 2 longword) |
| flt_addr | input | 24 | Faulting address |
| par_int_en | input | 1 | Parity interrupt enable flag |
| cpu_wr | input | 1 | Processor register write strobe |
| cpu_sel | input | 2 | Register select (0 general, 1 bus 0, 2 bus 1, 3 clear) |
| cpu_lane | input | 1 | Address bit 0 for byte reads |
| rd_byte | output | 8 | Byte-wide read data |
| rd_word | output | 16 | Word-wide read data |
| rd_long | output | 32 | Longword read data |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 16-bit status words and the parity flag at bit 10. These defaults make every address byte and every tag value visible through the read port. The vector table chains faults so that the class 2 and class 3 entries must keep a general status value left by an earlier entry. The directed tests then cover byte lanes, the clear register, a fault and a clear in the same cycle, and ignored writes.

// File: rtl/bus_fault_pkg.sv
package bus_fault_pkg;

   typedef enum logic [1:0] {
      FC_PAGE   = 2'd0,
      FC_USERIO = 2'd1,
      FC_KERNEL = 2'd2,
      FC_NOWE   = 2'd3
   } fault_class_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   localparam logic [1:0] SEL_GSTAT  = 2'd0;
   localparam logic [1:0] SEL_BSTAT0 = 2'd1;
   localparam logic [1:0] SEL_BSTAT1 = 2'd2;
   localparam logic [1:0] SEL_CLEAR  = 2'd3;

   localparam int NUM_WORDS = 3;

endpackage

// File: rtl/fault_encoder.sv
module fault_encoder #(
   parameter int ADDR_W  = 24,
   parameter int REG_W   = 16,
   parameter int PIE_BIT = 10
) (
   input  logic [1:0]        cls,
   input  logic              is_write,
   input  logic [1:0]        size,
   input  logic [ADDR_W-1:0] addr,
   input  logic              pie,
   output logic              gs_load,
   output logic [REG_W-1:0]  gs_val,
   output logic [REG_W-1:0]  b0_val,
   output logic [REG_W-1:0]  b1_val
);
   import bus_fault_pkg::*;

   localparam int HI_W = ADDR_W - 16;
   localparam logic [REG_W-1:0] CODE_PAGE_WR = 16'h8BFF;
   localparam logic [REG_W-1:0] CODE_UIO_WR  = 16'h9AFF;
   localparam logic [REG_W-1:0] READ_MARK    = 16'h4000;
   localparam logic [REG_W-1:0] PIE_MARK     = REG_W'(1) << PIE_BIT;

   logic [7:0] tag;
   logic [7:0] hi_byte;

   always_comb begin
      gs_load = (cls == FC_PAGE) || (cls == FC_USERIO);
      gs_val  = (cls == FC_PAGE) ? CODE_PAGE_WR : CODE_UIO_WR;
      if (!is_write) gs_val = gs_val | READ_MARK;
      if (pie)       gs_val = gs_val | PIE_MARK;
   end

   always_comb begin
      if (size == SZ_BYTE) tag = addr[0] ? 8'h7D : 8'h7E;
      else                 tag = 8'h7F;
   end

   assign hi_byte = 8'(addr[ADDR_W-1:16]);
   assign b0_val  = {tag, hi_byte};
   assign b1_val  = addr[15:0];

   if (HI_W < 1 || HI_W > 8) begin : g_bad_addr
      $error("fault_encoder: ADDR_W must be 17..24");
   end
   if (REG_W != 16) begin : g_bad_reg
      $error("fault_encoder: REG_W must be 16");
   end
   if (PIE_BIT < 0 || PIE_BIT >= REG_W) begin : g_bad_pie
      $error("fault_encoder: PIE_BIT out of range");
   end

endmodule

// File: rtl/status_word.sv
module status_word #(
   parameter int               REG_W   = 16,
   parameter logic [REG_W-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic             clr,
   input  logic [REG_W-1:0] d,
   output logic [REG_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= RST_VAL;
      else if (ld)  q <= d;
      else if (clr) q <= RST_VAL;
   end
endmodule

// File: rtl/status_readout.sv
module status_readout #(
   parameter int REG_W = 16
) (
   input  logic [1:0]       sel,
   input  logic             lane,
   input  logic [REG_W-1:0] w0,
   input  logic [REG_W-1:0] w1,
   input  logic [REG_W-1:0] w2,
   output logic [7:0]       rd_byte,
   output logic [REG_W-1:0] rd_word,
   output logic [2*REG_W-1:0] rd_long
);
   import bus_fault_pkg::*;

   always_comb begin
      case (sel)
         SEL_GSTAT:  rd_word = w0;
         SEL_BSTAT0: rd_word = w1;
         SEL_BSTAT1: rd_word = w2;
         default:    rd_word = '1;
      endcase
   end

   assign rd_byte = lane ? rd_word[7:0] : rd_word[15:8];
   assign rd_long = {rd_word, rd_word};
endmodule

// File: rtl/fault_status_regs.sv
module fault_status_regs #(
   parameter int ADDR_W  = 24,
   parameter int REG_W   = 16,
   parameter int PIE_BIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flt_valid,
   input  logic [1:0]        flt_class,
   input  logic              flt_write,
   input  logic [1:0]        flt_size,
   input  logic [ADDR_W-1:0] flt_addr,
   input  logic              par_int_en,
   input  logic              cpu_wr,
   input  logic [1:0]        cpu_sel,
   input  logic              cpu_lane,
   output logic [7:0]        rd_byte,
   output logic [REG_W-1:0]  rd_word,
   output logic [2*REG_W-1:0] rd_long
);
   import bus_fault_pkg::*;

   localparam logic [REG_W-1:0] RST_VAL = '1;

   logic             enc_gs_load;
   logic [REG_W-1:0] enc_gs, enc_b0, enc_b1;
   logic             clr_all;
   logic [NUM_WORDS-1:0] ld_vec;
   logic [REG_W-1:0] d_arr [NUM_WORDS];
   logic [REG_W-1:0] q_arr [NUM_WORDS];
   logic [REG_W-1:0] gs_q, b0_q, b1_q;

   fault_encoder #(.ADDR_W(ADDR_W), .REG_W(REG_W), .PIE_BIT(PIE_BIT)) u_enc (
      .cls(flt_class), .is_write(flt_write), .size(flt_size), .addr(flt_addr),
      .pie(par_int_en), .gs_load(enc_gs_load), .gs_val(enc_gs),
      .b0_val(enc_b0), .b1_val(enc_b1)
   );

   assign clr_all  = cpu_wr && (cpu_sel == SEL_CLEAR);
   assign ld_vec   = {flt_valid, flt_valid, flt_valid && enc_gs_load};
   assign d_arr[0] = enc_gs;
   assign d_arr[1] = enc_b0;
   assign d_arr[2] = enc_b1;

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      status_word #(.REG_W(REG_W), .RST_VAL(RST_VAL)) u_word (
         .clk(clk), .rst_n(rst_n), .ld(ld_vec[i]), .clr(clr_all),
         .d(d_arr[i]), .q(q_arr[i])
      );
   end

   assign gs_q = q_arr[0];
   assign b0_q = q_arr[1];
   assign b1_q = q_arr[2];

   status_readout #(.REG_W(REG_W)) u_rd (
      .sel(cpu_sel), .lane(cpu_lane), .w0(gs_q), .w1(b0_q), .w2(b1_q),
      .rd_byte(rd_byte), .rd_word(rd_word), .rd_long(rd_long)
   );

endmodule

// File: rtl/fault_status_regs_chk.sv
module fault_status_regs_chk #(
   parameter int ADDR_W  = 24,
   parameter int REG_W   = 16,
   parameter int PIE_BIT = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flt_valid,
   input logic [1:0]        flt_class,
   input logic              flt_write,
   input logic [1:0]        flt_size,
   input logic [ADDR_W-1:0] flt_addr,
   input logic              par_int_en,
   input logic              cpu_wr,
   input logic [1:0]        cpu_sel,
   input logic [REG_W-1:0]  rd_word,
   input logic [2*REG_W-1:0] rd_long,
   input logic [REG_W-1:0]  gs_q,
   input logic [REG_W-1:0]  b0_q,
   input logic [REG_W-1:0]  b1_q
);
   logic clr_w;
   logic gs_class;
   assign clr_w    = cpu_wr && (cpu_sel == 2'd3);
   assign gs_class = (flt_class == 2'd0) || (flt_class == 2'd1);

   a_r1_reset_ones: assert property (@(posedge clk)
      $rose(rst_n) |-> (gs_q == 16'hFFFF && b0_q == 16'hFFFF && b1_q == 16'hFFFF));

   a_r2_page_write: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid && flt_class == 2'd0 && flt_write && !par_int_en |=> gs_q == 16'h8BFF);

   a_r2_uio_read: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid && flt_class == 2'd1 && !flt_write && !par_int_en |=> gs_q == 16'hDAFF);

   a_r3_pie_mark: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid && gs_class && par_int_en |=> gs_q[PIE_BIT]);

   a_r4_gstat_kept: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid && !gs_class && !clr_w |=> $stable(gs_q));

   a_r5_wide_tag: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid && flt_size != 2'd0 |=> b0_q[15:8] == 8'h7F);

   a_r6_low_addr: assert property (@(posedge clk) disable iff (!rst_n)
      flt_valid |=> b1_q == $past(flt_addr[15:0]));

   a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w && !flt_valid |=> (gs_q == 16'hFFFF && b0_q == 16'hFFFF && b1_q == 16'hFFFF));

   a_r10_long_dup: assert property (@(posedge clk) disable iff (!rst_n)
      rd_long == {rd_word, rd_word});

   a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !flt_valid && !clr_w |=> ($stable(gs_q) && $stable(b0_q) && $stable(b1_q)));

endmodule

bind fault_status_regs fault_status_regs_chk #(
   .ADDR_W(ADDR_W), .REG_W(REG_W), .PIE_BIT(PIE_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_class(flt_class),
   .flt_write(flt_write), .flt_size(flt_size), .flt_addr(flt_addr),
   .par_int_en(par_int_en), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
   .rd_word(rd_word), .rd_long(rd_long), .gs_q(gs_q), .b0_q(b0_q), .b1_q(b1_q)
);

// File: tb/fault_status_regs_test.sv
`timescale 1ns/1ps
module fault_status_regs_test;

   typedef struct packed {
      logic [1:0]  cls;
      logic        wr;
      logic [1:0]  sz;
      logic        pie;
      logic [23:0] addr;
      logic [15:0] g;
      logic [15:0] b0;
      logic [15:0] b1;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 1'b1, 2'd0, 1'b0, 24'h123456, 16'h8BFF, 16'h7E12, 16'h3456},
      '{2'd1, 1'b1, 2'd1, 1'b1, 24'hABCDEF, 16'h9EFF, 16'h7FAB, 16'hCDEF},
      '{2'd0, 1'b0, 2'd2, 1'b0, 24'h000001, 16'hCBFF, 16'h7F00, 16'h0001},
      '{2'd1, 1'b0, 2'd0, 1'b1, 24'h7FFFFF, 16'hDEFF, 16'h7D7F, 16'hFFFF},
      '{2'd2, 1'b0, 2'd1, 1'b1, 24'h051234, 16'hDEFF, 16'h7F05, 16'h1234},
      '{2'd3, 1'b1, 2'd0, 1'b0, 24'h3C0A01, 16'hDEFF, 16'h7D3C, 16'h0A01},
      '{2'd0, 1'b0, 2'd0, 1'b1, 24'h400000, 16'hCFFF, 16'h7E40, 16'h0000},
      '{2'd1, 1'b1, 2'd2, 1'b0, 24'hFFFFFE, 16'h9AFF, 16'h7FFF, 16'hFFFE}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flt_valid = 1'b0;
   logic [1:0]  flt_class = '0;
   logic        flt_write = 1'b0;
   logic [1:0]  flt_size = '0;
   logic [23:0] flt_addr = '0;
   logic        par_int_en = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [1:0]  cpu_sel = '0;
   logic        cpu_lane = 1'b0;
   logic [7:0]  rd_byte;
   logic [15:0] rd_word;
   logic [31:0] rd_long;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fault_status_regs uut (
      .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_class(flt_class),
      .flt_write(flt_write), .flt_size(flt_size), .flt_addr(flt_addr),
      .par_int_en(par_int_en), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
      .cpu_lane(cpu_lane), .rd_byte(rd_byte), .rd_word(rd_word), .rd_long(rd_long)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic read_word(input logic [1:0] sel, output logic [15:0] val);
      cpu_sel = sel;
      #1;
      val = rd_word;
   endtask

   task automatic check_all(input string req, input logic [15:0] g, input logic [15:0] b0,
                            input logic [15:0] b1);
      logic [15:0] v;
      read_word(2'd0, v); check({req, " gstat"}, {16'h0, v}, {16'h0, g});
      read_word(2'd1, v); check({req, " bstat0"}, {16'h0, v}, {16'h0, b0});
      read_word(2'd2, v); check({req, " bstat1"}, {16'h0, v}, {16'h0, b1});
   endtask

   // drive at negedge, captured at next posedge, inputs released at following negedge
   task automatic fault(input logic [1:0] c, input logic w, input logic [1:0] s,
                        input logic p, input logic [23:0] a, input logic clr_too);
      @(negedge clk);
      flt_valid = 1'b1; flt_class = c; flt_write = w; flt_size = s;
      par_int_en = p; flt_addr = a;
      if (clr_too) begin cpu_wr = 1'b1; cpu_sel = 2'd3; end
      @(negedge clk);
      flt_valid = 1'b0; cpu_wr = 1'b0;
   endtask

   task automatic cpu_write(input logic [1:0] sel);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_sel = sel;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check_all("R1", 16'hFFFF, 16'hFFFF, 16'hFFFF);

      // R2 R3 R4 R5 R6: fault table
      for (int i = 0; i < NV; i++) begin
         fault(VEC[i].cls, VEC[i].wr, VEC[i].sz, VEC[i].pie, VEC[i].addr, 1'b0);
         check_all($sformatf("R2/R3/R4/R5/R6 vec%0d", i), VEC[i].g, VEC[i].b0, VEC[i].b1);
      end

      // R10 byte lanes and longword on gstat = 9AFF
      cpu_sel = 2'd0; cpu_lane = 1'b0; #1;
      check("R10 byte even", {24'h0, rd_byte}, 32'h9A);
      cpu_lane = 1'b1; #1;
      check("R10 byte odd", {24'h0, rd_byte}, 32'hFF);
      check("R10 long", rd_long, 32'h9AFF9AFF);
      cpu_sel = 2'd1; cpu_lane = 1'b0; #1;
      check("R10 bstat0 long", rd_long, 32'h7FFF7FFF);
      read_word(2'd3, v);
      check("R10 clear reg reads ones", {16'h0, v}, 32'h0000FFFF);

      // R9 writes to status words ignored
      cpu_write(2'd0); cpu_write(2'd1); cpu_write(2'd2);
      check_all("R9", 16'h9AFF, 16'h7FFF, 16'hFFFE);

      // R11 hold over idle cycles
      repeat (5) @(negedge clk);
      check_all("R11", 16'h9AFF, 16'h7FFF, 16'hFFFE);

      // R7 clear
      cpu_write(2'd3);
      check_all("R7", 16'hFFFF, 16'hFFFF, 16'hFFFF);

      // R4 kernel fault after clear keeps gstat at FFFF
      fault(2'd2, 1'b1, 2'd0, 1'b1, 24'h000002, 1'b0);
      check_all("R4 after clear", 16'hFFFF, 16'h7E00, 16'h0002);

      // R8 fault with simultaneous clear
      fault(2'd0, 1'b1, 2'd0, 1'b1, 24'h9A0103, 1'b1);
      check_all("R8", 16'h8FFF, 16'h7D9A, 16'h0103);

      // R1 reset again returns ones
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check_all("R1 re-reset", 16'hFFFF, 16'hFFFF, 16'hFFFF);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule